// File: doc/BRIEF.md
# Multibank Row State Tracker

This block keeps a record of which banks of a multibank DRAM-style device hold an open row, and which row that is. It decodes one command per clock. The commands are open-row, read, write, close, refresh and idle. Each command is checked against the recorded state. A legal command updates the state and produces an acceptance pulse. A command that breaks the bank rules produces an error pulse and changes nothing.

Reads and writes can ask for a self-timed close. The bank then stays open while its data burst runs, and closes by itself on the clock after the burst ends. The length of the burst is chosen per command: a full burst of eight beats or a chopped burst of four. While such a close is pending, the bank accepts no further access and no explicit close.

A controller or a protocol monitor places this block beside the command path. It reads the per-bank open flags and row numbers to decide whether a row hit is possible.

Top module: `bank_row_tracker`

## Requirements
- R1: Reset, whether applied at the start or in the middle of a run, leaves every bank closed and both `cmd_ok` and `cmd_err` low.
- R2: An open-row command (`cmd` = 1) to a closed bank opens that bank and stores `row`. `cmd_ok` is high for the one cycle after the clock edge that samples the command.
- R3: An open-row command to a bank that is already open raises `cmd_err` for one cycle, and leaves the open flags and the stored row unchanged.
- R4: A read (`cmd` = 2) or write (`cmd` = 3) to an open bank with no pending self-close is accepted, and `col` appears on `burst_col` in the next cycle.
- R5: A read or write to a closed bank raises `cmd_err` and changes no state.
- R6: A read or write with `ap_flag` = 1 and `chop` = 0 (eight beats) keeps the bank open through the 4 edges that follow the command edge. The bank closes at the 5th edge.
- R7: A read or write with `ap_flag` = 1 and `chop` = 1 (four beats) keeps the bank open through the 2 edges that follow the command edge. The bank closes at the 3rd edge.
- R8: A read, write or single-bank close to a bank whose self-close is pending is rejected with `cmd_err`.
- R9: A close (`cmd` = 4) with `ap_flag` = 0 closes only the addressed bank. A close to a bank that is already closed is accepted and changes nothing.
- R10: A close with `ap_flag` = 1 closes all banks in one cycle. It is rejected if any bank has a self-close pending.
- R11: A refresh (`cmd` = 5) is accepted only when all banks are closed. Otherwise it raises `cmd_err`. It never changes the bank state.
- R12: An idle command (`cmd` = 0) raises neither pulse. The unused codes 6 and 7 raise `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code: 0 idle, 1 open row, 2 read, 3 write, 4 close, 5 refresh |
| bank | input | BANK_W (3) | Target bank |
| row | input | ROW_W (14) | Row to open (open-row command only) |
| col | input | COL_W (10) | Starting column (read and write only) |
| ap_flag | input | 1 | On read or write: self-close after the burst. On close: act on all banks |
| chop | input | 1 | Burst of four beats when 1, eight beats when 0 |
| cmd_ok | output | 1 | Registered pulse: the previous command was accepted |
| cmd_err | output | 1 | Registered pulse: the previous command was rejected |
| burst_col | output | COL_W (10) | Starting column of the last accepted read or write |
| bank_open | output | NUM_BANKS (8) | Per-bank open flag |
| open_rows | output | NUM_BANKS*ROW_W (112) | Stored row of each bank; bank k occupies bits [k*ROW_W +: ROW_W] |

## Verification
The decoder is driven with the same command type under opposite bank states: open-row to a closed bank and then to an open one, reads to open and closed banks, and refresh with banks open and with all banks closed. These pairs show that legality depends on the recorded state and not on the command alone. Self-closing accesses are issued with both burst lengths, and the open flags are sampled on every edge around the expected close. This catches a close that comes one edge early or one edge late. Accesses issued while a self-close is pending, all-bank closes, out-of-range codes and a reset in mid-run show that pending work blocks conflicting commands and that rejected commands leave the rows untouched.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // Number of edges a bank stays open after the command edge before a
  // self-close fires: the burst duration for the chosen chop setting.
  function automatic int unsigned burst_hold(input logic chop,
                                             input int unsigned full_cyc,
                                             input int unsigned chop_cyc);
    return chop ? chop_cyc : full_cyc;
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/brt_decode.sv
module brt_decode
  import brt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [2:0]           cmd,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 ap_flag,
  input  logic [NUM_BANKS-1:0] open_vec,
  input  logic [NUM_BANKS-1:0] pend_vec,
  output logic                 legal,
  output logic                 illegal,
  output logic                 access_ok,
  output logic [NUM_BANKS-1:0] act_vec,
  output logic [NUM_BANKS-1:0] pre_vec,
  output logic [NUM_BANKS-1:0] ap_vec
);

  logic [NUM_BANKS-1:0] sel;
  logic                 is_cmd;
  cmd_e                 c;

  always_comb begin
    c         = cmd_e'(cmd);
    sel       = '0;
    sel[bank] = 1'b1;
    legal     = 1'b0;
    is_cmd    = 1'b1;
    act_vec   = '0;
    pre_vec   = '0;
    ap_vec    = '0;
    access_ok = 1'b0;
    case (c)
      CMD_NOP: is_cmd = 1'b0;
      CMD_ACT: begin
        legal = !open_vec[bank];
        if (legal) act_vec = sel;
      end
      CMD_RD, CMD_WR: begin
        legal     = open_vec[bank] && !pend_vec[bank];
        access_ok = legal && is_access(c);
        if (legal && ap_flag) ap_vec = sel;
      end
      CMD_PRE: begin
        if (ap_flag) begin
          legal = (pend_vec == '0);
          if (legal) pre_vec = '1;
        end else begin
          legal = !pend_vec[bank];
          if (legal) pre_vec = sel;
        end
      end
      CMD_REF: legal = (open_vec == '0);
      default: legal = 1'b0;
    endcase
    illegal = is_cmd && !legal;
  end

endmodule

// File: rtl/brt_bank.sv
module brt_bank
  import brt_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int FULL_CYC = 4,
  parameter int CHOP_CYC = 2,
  localparam int CNT_W   = $clog2(FULL_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_hit,
  input  logic [ROW_W-1:0] row_in,
  input  logic             pre_hit,
  input  logic             ap_start,
  input  logic             chop,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q,
  output logic             ap_pend,
  output logic             ap_fire
);

  logic [CNT_W-1:0] cnt_q;

  assign ap_fire = ap_pend && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      row_q   <= '0;
      ap_pend <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (act_hit) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end else if (pre_hit || ap_fire) begin
        open_q <= 1'b0;
      end
      if (ap_start) begin
        ap_pend <= 1'b1;
        cnt_q   <= CNT_W'(burst_hold(chop, FULL_CYC, CHOP_CYC));
      end else if (ap_pend) begin
        if (cnt_q == '0) ap_pend <= 1'b0;
        else             cnt_q   <= cnt_q - 1'b1;
      end
    end
  end

  a_r6_fire_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire |=> !open_q);
  a_r8_pend_means_open: assert property (@(posedge clk) disable iff (!rst_n)
    ap_pend |-> open_q);
  a_r2_act_loads_row: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> (open_q && row_q == $past(row_in)));
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ap_pend |-> (cnt_q <= CNT_W'(FULL_CYC)));

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int FULL_CYC  = 4,
  parameter int CHOP_CYC  = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cmd,
  input  logic [BANK_W-1:0]          bank,
  input  logic [ROW_W-1:0]           row,
  input  logic [COL_W-1:0]           col,
  input  logic                       ap_flag,
  input  logic                       chop,
  output logic                       cmd_ok,
  output logic                       cmd_err,
  output logic [COL_W-1:0]           burst_col,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows
);

  logic [NUM_BANKS-1:0] open_vec, pend_vec, fire_vec;
  logic [NUM_BANKS-1:0] act_vec, pre_vec, ap_vec;
  logic                 dec_legal, dec_illegal, dec_access;

  brt_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .cmd       (cmd),
    .bank      (bank),
    .ap_flag   (ap_flag),
    .open_vec  (open_vec),
    .pend_vec  (pend_vec),
    .legal     (dec_legal),
    .illegal   (dec_illegal),
    .access_ok (dec_access),
    .act_vec   (act_vec),
    .pre_vec   (pre_vec),
    .ap_vec    (ap_vec)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    brt_bank #(
      .ROW_W    (ROW_W),
      .FULL_CYC (FULL_CYC),
      .CHOP_CYC (CHOP_CYC)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_hit  (act_vec[k]),
      .row_in   (row),
      .pre_hit  (pre_vec[k]),
      .ap_start (ap_vec[k]),
      .chop     (chop),
      .open_q   (open_vec[k]),
      .row_q    (open_rows[k*ROW_W +: ROW_W]),
      .ap_pend  (pend_vec[k]),
      .ap_fire  (fire_vec[k])
    );
  end

  assign bank_open = open_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ok    <= 1'b0;
      cmd_err   <= 1'b0;
      burst_col <= '0;
    end else begin
      cmd_ok  <= dec_legal;
      cmd_err <= dec_illegal;
      if (dec_access) burst_col <= col;
    end
  end

  a_r12_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ok, cmd_err}));
  a_r11_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_legal && cmd == CMD_REF) |-> (open_vec == '0));
  a_r3_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_illegal && fire_vec == '0) |=> $stable(open_vec));
  a_r10_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_legal && cmd == CMD_PRE && ap_flag) |=> (open_vec == '0));

endmodule

// File: tb/bank_row_tracker_bench.sv
module bank_row_tracker_bench;

  localparam int NB = 8;
  localparam int RW = 14;
  localparam int CW = 10;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = '0;
  logic [BW-1:0] bank = '0;
  logic [RW-1:0] row = '0;
  logic [CW-1:0] col = '0;
  logic          ap_flag = 1'b0;
  logic          chop = 1'b0;
  logic          cmd_ok, cmd_err;
  logic [CW-1:0] burst_col;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] open_rows;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bank_row_tracker u_bank_row_tracker (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .row(row), .col(col),
    .ap_flag(ap_flag), .chop(chop), .cmd_ok(cmd_ok), .cmd_err(cmd_err),
    .burst_col(burst_col), .bank_open(bank_open), .open_rows(open_rows)
  );

  // {cmd, bank, row, col, ap, chop, exp_ok, exp_err, exp_open, req}
  localparam int NV = 29;
  localparam logic [45:0] VEC [NV] = '{
    {3'd1, 3'd0, 14'd5, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 4'd2},  // R2
    {3'd1, 3'd0, 14'd9, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 4'd3},  // R3
    {3'd2, 3'd1, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 4'd5},  // R5
    {3'd2, 3'd0, 14'd0, 10'd8, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 4'd4},  // R4
    {3'd1, 3'd3, 14'd7, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h09, 4'd2},
    {3'd4, 3'd3, 14'd0, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 4'd9},  // R9
    {3'd4, 3'd3, 14'd0, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 4'd9},
    {3'd5, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 4'd11}, // R11
    {3'd3, 3'd0, 14'd0, 10'd4, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 4'd6},  // R6 start
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 4'd12}, // R12
    {3'd2, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 4'd8},  // R8
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 4'd6},
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 4'd6},
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6},
    {3'd1, 3'd2, 14'd3, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04, 4'd2},
    {3'd2, 3'd2, 14'd0, 10'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h04, 4'd7},  // R7 start
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 4'd7},
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 4'd7},
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7},
    {3'd5, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'd11},
    {3'd6, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 4'd12},
    {3'd1, 3'd5, 14'd1, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 4'd2},
    {3'd1, 3'd6, 14'd2, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h60, 4'd2},
    {3'd4, 3'd0, 14'd0, 10'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 4'd10}, // R10
    {3'd1, 3'd7, 14'd4, 10'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 4'd2},
    {3'd3, 3'd7, 14'd0, 10'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 4'd7},
    {3'd4, 3'd0, 14'd0, 10'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 4'd10},
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 4'd7},
    {3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [BW-1:0] b,
                       input logic [RW-1:0] r, input logic [CW-1:0] cl,
                       input logic a, input logic ch);
    @(negedge clk);
    cmd = c; bank = b; row = r; col = cl; ap_flag = a; chop = ch;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(bank_open == '0 && !cmd_ok && !cmd_err, "R1", "reset state",
          RW'({cmd_ok, cmd_err, bank_open}), '0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      issue(v[45:43], v[42:40], v[39:26], v[25:16], v[15], v[14]);
      check({cmd_ok, cmd_err, bank_open} == v[13:4],
            $sformatf("R%0d", v[3:0]), $sformatf("vector %0d ok/err/open", i),
            RW'({cmd_ok, cmd_err, bank_open}), RW'(v[13:4]));
    end

    // R2: maximum row value is stored for bank 4
    issue(3'd1, 3'd4, 14'h3FFF, 10'd0, 1'b0, 1'b0);
    check(open_rows[4*RW +: RW] == 14'h3FFF, "R2", "row of bank 4",
          open_rows[4*RW +: RW], 14'h3FFF);
    // R4: column reported
    issue(3'd3, 3'd4, 14'd0, 10'h3FF, 1'b0, 1'b0);
    check(cmd_ok && burst_col == 10'h3FF, "R4", "burst_col",
          RW'(burst_col), RW'(10'h3FF));
    // R3: rejected re-open keeps row
    issue(3'd1, 3'd4, 14'd1, 10'd0, 1'b0, 1'b0);
    check(cmd_err && open_rows[4*RW +: RW] == 14'h3FFF, "R3", "row kept",
          open_rows[4*RW +: RW], 14'h3FFF);
    // R5: rejected read keeps burst_col
    issue(3'd2, 3'd1, 14'd0, 10'd7, 1'b0, 1'b0);
    check(cmd_err && burst_col == 10'h3FF, "R5", "burst_col kept",
          RW'(burst_col), RW'(10'h3FF));
    // R8: single close to a pending bank rejected
    issue(3'd2, 3'd4, 14'd0, 10'd1, 1'b1, 1'b0);
    issue(3'd4, 3'd4, 14'd0, 10'd0, 1'b0, 1'b0);
    check(cmd_err && bank_open == 8'h10, "R8", "close while pending",
          RW'({cmd_err, bank_open}), RW'({1'b1, 8'h10}));
    issue(3'd7, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0);
    check(cmd_err && !cmd_ok, "R12", "code 7", RW'({cmd_ok, cmd_err}), RW'(2'b01));

    // R1: reset in mid-run
    issue(3'd0, 3'd0, 14'd0, 10'd0, 1'b0, 1'b0);
    issue(3'd1, 3'd1, 14'd2, 10'd0, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check(bank_open == '0 && !cmd_ok && !cmd_err, "R1", "mid-run reset",
          RW'({cmd_ok, cmd_err, bank_open}), '0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule